// File: doc/BRIEF.md
# Clock Event Status and Interrupt Register

This block is the event status register of a real-time clock. Three one-cycle strobes arrive from neighbouring logic: the end of an update cycle, an alarm match and a periodic tick at the interval chosen by a 4-bit rate field. Each strobe sets a sticky flag. A combined interrupt request flag is set whenever a flag and its enable are both set, and the interrupt pin follows that request flag. Software sees all of this as one read-only 8-bit word, and a read strobe clears the four event-related bits in a single step.

The same word also carries a 32 kHz output enable bit. This bit can be written to 1 only while the 3-bit oscillator select holds one permitted code, 3'b011. Any other code forces the bit to 0. When the bit is set and the square-wave enable is also set, the block tells the square-wave output mux to carry the 32.768 kHz clock. The clock counters, the alarm comparator and the periodic divider sit outside this block.

Top module: `rtc_evt_status`

## Requirements
- R1: An update strobe (`upd_evt`) sets status bit 4 at the next clock edge. The bit stays set until a read clears it.
- R2: An alarm strobe (`alm_evt`) sets status bit 5 at the next clock edge. The bit stays set until a read clears it.
- R3: A periodic strobe (`per_evt`) sets status bit 6 at the next clock edge. The bit stays set until a read clears it.
- R4: Status bit 7, the interrupt request, is set at the same edge as any event flag whose enable is 1 (`upd_ie`, `alm_ie` or `per_ie`). An event whose enable is 0 does not set it. Output `irq` always equals bit 7.
- R5: During a cycle with `rd_stb` high, `status` still shows the flags. At the next edge, bits 7 to 4 become 0, unless R6 applies.
- R6: If a strobe arrives in the same cycle as `rd_stb`, its flag is still set after that edge. If the matching enable is 1, the interrupt request is also still set.
- R7: A write (`k32_wr` high, with the value on `k32_wdata`) changes status bit 1 at the next edge only while `osc_sel` is 3'b011. A write under any other code leaves bit 1 at 0.
- R8: At any edge where `osc_sel` differs from 3'b011, bit 1 becomes 0. A read does not clear bit 1.
- R9: `sqw_32k` is 1 exactly when `sqw_en` is 1 and status bit 1 is 1.
- R10: Reset clears the whole word. Bits 3, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_evt | input | 1 | End-of-update strobe |
| alm_evt | input | 1 | Alarm match strobe |
| per_evt | input | 1 | Periodic tick strobe |
| upd_ie | input | 1 | Update interrupt enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| per_ie | input | 1 | Periodic interrupt enable |
| osc_sel | input | 3 | Oscillator select code |
| sqw_en | input | 1 | Square-wave output enable |
| k32_wr | input | 1 | Write strobe for the 32 kHz enable |
| k32_wdata | input | 1 | Value written to the 32 kHz enable |
| rd_stb | input | 1 | Status read strobe, clears event bits |
| status | output | 8 | Status word |
| irq | output | 1 | Interrupt request pin |
| sqw_32k | output | 1 | Selects 32.768 kHz onto the square-wave pin |

## Verification
Every flag, the interrupt request and the 32 kHz enable are registered. Their effect shows one edge after the cycle in which the strobe, read, write or select change is applied. `sqw_32k` follows `sqw_en` within the same cycle, but it still reflects the registered enable bit.

The driver applies each stimulus just after a falling edge and pushes the expected word into the queue. The monitor pops that item just after the following rising edge, so each result is compared in the cycle it is due. Separate direct checks, made while `rd_stb` is held high and before the clearing edge, confirm that the word is still visible in the read cycle.

// File: rtl/rtc_evt_status.sv
module rtc_evt_status #(
  parameter logic [2:0] K32_OSC_CODE = 3'b011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_evt,
  input  logic       alm_evt,
  input  logic       per_evt,
  input  logic       upd_ie,
  input  logic       alm_ie,
  input  logic       per_ie,
  input  logic [2:0] osc_sel,
  input  logic       sqw_en,
  input  logic       k32_wr,
  input  logic       k32_wdata,
  input  logic       rd_stb,
  output logic [7:0] status,
  output logic       irq,
  output logic       sqw_32k
);

  logic upd_f, alm_f, per_f, req_f, k32_f;
  logic upd_n, alm_n, per_n, req_n, k32_n;
  logic k32_ok;

  // an arriving event outranks a clearing read
  assign upd_n = upd_evt | (upd_f & ~rd_stb);
  assign alm_n = alm_evt | (alm_f & ~rd_stb);
  assign per_n = per_evt | (per_f & ~rd_stb);
  assign req_n = (req_f & ~rd_stb)
               | (upd_ie & upd_n) | (alm_ie & alm_n) | (per_ie & per_n);

  assign k32_ok = (osc_sel == K32_OSC_CODE);
  assign k32_n  = k32_ok & (k32_wr ? k32_wdata : k32_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_f <= 1'b0;
      alm_f <= 1'b0;
      per_f <= 1'b0;
      req_f <= 1'b0;
      k32_f <= 1'b0;
    end else begin
      upd_f <= upd_n;
      alm_f <= alm_n;
      per_f <= per_n;
      req_f <= req_n;
      k32_f <= k32_n;
    end
  end

  assign status  = {req_f, per_f, alm_f, upd_f, 2'b00, k32_f, 1'b0};
  assign irq     = req_f;
  assign sqw_32k = sqw_en & k32_f;

endmodule

module rtc_evt_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_evt,
  input logic       alm_evt,
  input logic       per_evt,
  input logic       upd_ie,
  input logic       rd_stb,
  input logic [2:0] osc_sel,
  input logic [7:0] status,
  input logic       irq,
  input logic       sqw_32k,
  input logic       sqw_en
);
  p_upd_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> status[4]);
  p_alm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alm_evt |=> status[5]);
  p_per_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> status[6]);
  p_irq_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && upd_ie) |=> irq);
  p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !upd_evt && !alm_evt && !per_evt) |=> (status[6:4] == 3'b000));
  p_k32_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_sel != 3'b011) |=> !status[1]);
  p_sqw_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_32k |-> sqw_en);
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b00) && !status[0]);
endmodule

bind rtc_evt_status rtc_evt_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .alm_evt(alm_evt),
  .per_evt(per_evt), .upd_ie(upd_ie), .rd_stb(rd_stb), .osc_sel(osc_sel),
  .status(status), .irq(irq), .sqw_32k(sqw_32k), .sqw_en(sqw_en)
);

// File: tb/tb_rtc_evt_status.sv
`timescale 1ns/1ps
module tb_rtc_evt_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_evt = 0, alm_evt = 0, per_evt = 0;
  logic upd_ie = 0, alm_ie = 0, per_ie = 0;
  logic [2:0] osc_sel = 3'b000;
  logic sqw_en = 0, k32_wr = 0, k32_wdata = 0, rd_stb = 0;
  logic [7:0] status;
  logic irq, sqw_32k;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    logic       sqw;
    string      req;
  } exp_t;
  exp_t q[$];

  logic mu = 0, ma = 0, mp = 0, mi = 0, mk = 0;

  always #5 clk = ~clk;

  rtc_evt_status dut (
    .clk(clk), .rst_n(rst_n), .upd_evt(upd_evt), .alm_evt(alm_evt),
    .per_evt(per_evt), .upd_ie(upd_ie), .alm_ie(alm_ie), .per_ie(per_ie),
    .osc_sel(osc_sel), .sqw_en(sqw_en), .k32_wr(k32_wr),
    .k32_wdata(k32_wdata), .rd_stb(rd_stb), .status(status), .irq(irq),
    .sqw_32k(sqw_32k)
  );

  task automatic cmp(input logic [7:0] st, input logic i, input logic s, input exp_t e);
    total++;
    if (st !== e.st || i !== e.irq || s !== e.sqw) begin
      bad++;
      $display("FAIL %s: status=%b irq=%b sqw=%b expected status=%b irq=%b sqw=%b",
               e.req, st, i, s, e.st, e.irq, e.sqw);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the word due after the edge
  task automatic step(input logic u, input logic a, input logic p,
                      input logic uie, input logic aie, input logic pie,
                      input logic [2:0] osc, input logic sq,
                      input logic wr, input logic wd, input logic rd,
                      input string req);
    exp_t e;
    logic nu, na, np;
    @(negedge clk);
    upd_evt = u; alm_evt = a; per_evt = p;
    upd_ie = uie; alm_ie = aie; per_ie = pie;
    osc_sel = osc; sqw_en = sq; k32_wr = wr; k32_wdata = wd; rd_stb = rd;
    nu = u | (mu & !rd);
    na = a | (ma & !rd);
    np = p | (mp & !rd);
    mi = (mi & !rd) | (uie & nu) | (aie & na) | (pie & np);
    mu = nu; ma = na; mp = np;
    if (osc != 3'b011) mk = 0;
    else if (wr) mk = wd;
    e.st = {mi, mp, ma, mu, 2'b00, mk, 1'b0};
    e.irq = mi;
    e.sqw = sq & mk;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input logic [2:0] osc, input logic sq, input string req);
    step(0,0,0, upd_ie,alm_ie,per_ie, osc, sq, 0,0,0, req);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) cmp(status, irq, sqw_32k, q.pop_front());
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r.st = 8'h00; r.irq = 0; r.sqw = 0; r.req = "R10 reset";
    cmp(status, irq, sqw_32k, r);

    // R1 R2 R3 with enables off: flags but no interrupt (R4)
    step(1,0,0, 0,0,0, 3'b000,0, 0,0,0, "R1 update sets bit4");
    idle(3'b000, 0, "R1 bit4 sticky");
    step(0,1,0, 0,0,0, 3'b000,0, 0,0,0, "R2 alarm sets bit5");
    step(0,0,1, 0,0,0, 3'b000,0, 0,0,0, "R3 periodic sets bit6, R4 no irq when disabled");
    // R5 word visible during read cycle
    @(negedge clk); rd_stb = 1;
    #1;
    r.st = 8'h70; r.irq = 0; r.sqw = 0; r.req = "R5 word visible during read";
    cmp(status, irq, sqw_32k, r);
    step(0,0,0, 0,0,0, 3'b000,0, 0,0,1, "R5 read clears flags");
    idle(3'b000, 0, "R5 flags stay clear");

    // R4 enabled pairs
    step(0,1,0, 0,1,0, 3'b000,0, 0,0,0, "R4 alarm with enable raises irq");
    step(0,0,0, 0,0,0, 3'b000,0, 0,0,1, "R5 read clears irq");
    step(0,0,1, 0,0,1, 3'b000,0, 0,0,0, "R4 periodic with enable");
    step(0,0,0, 0,0,0, 3'b000,0, 0,0,0, "R4 irq sticky after enable drops");
    step(0,0,0, 0,0,0, 3'b000,0, 0,0,1, "R5 read clears");
    step(1,0,0, 1,0,0, 3'b000,0, 0,0,0, "R4 update with enable");
    // R6 event during read wins
    step(1,0,0, 1,0,0, 3'b000,0, 0,0,1, "R6 update during read stays set");
    step(0,0,1, 0,0,0, 3'b000,0, 0,0,1, "R6 periodic during read, irq cleared");
    step(0,0,0, 0,0,0, 3'b000,0, 0,0,1, "R5 read clears");

    // R7 32k enable
    step(0,0,0, 0,0,0, 3'b010,1, 1,1,0, "R7 write ignored for wrong code");
    step(0,0,0, 0,0,0, 3'b011,1, 1,1,0, "R7 write accepted, R9 sqw on");
    step(0,0,0, 0,0,0, 3'b011,0, 0,0,1, "R8 read leaves bit1, R9 sqw off");
    step(0,0,0, 0,0,0, 3'b011,1, 0,0,0, "R9 sqw follows enable");
    step(0,0,0, 0,0,0, 3'b011,1, 1,0,0, "R7 write 0 clears bit1");
    step(0,0,0, 0,0,0, 3'b011,1, 1,1,0, "R7 rewrite 1");
    step(1,1,1, 1,1,1, 3'b011,1, 0,0,0, "R4 all sources, R10 unused zero");
    step(0,0,0, 1,1,1, 3'b111,1, 0,0,0, "R8 other code forces bit1 clear");
    step(0,0,0, 0,0,0, 3'b011,1, 0,0,0, "R8 bit1 stays clear on return");
    step(0,0,0, 0,0,0, 3'b011,1, 0,0,1, "R5 read clears all events");
    idle(3'b011, 0, "R10 quiet word");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule